// File: doc/BRIEF.md
# Frequency-Trimmed PTP Time Counter

A nanosecond time-of-day counter for precision time protocol use. On every tick of its 125 MHz reference it adds a fixed-point increment to a fractional accumulator. The whole nanoseconds that fall out of that sum advance two time values. One is a seconds plus nanoseconds time code, where the nanoseconds roll over at one billion. The other is a free-running 48-bit nanosecond count. The increment is a 32-bit word with 28 fractional bits, so the reset value of 0x8000_0000 gives exactly 8 ns per tick. Changing the word trims the rate of the clock.

Software reaches the block through a 16-bit strobe port. A new time code, a new free-running count and a new increment are first written into shadow copies and have no effect there. All of them are committed in one clock edge, on a frame-sync event, which software raises by taking a control bit from 0 to 1. Load-select bits choose which shadow copies that event commits. The same event can also snapshot the time code into heartbeat registers. Software reads those registers under a freeze handshake so that a later capture cannot tear a read.

Top module: `ptp_trim_clock`

## Requirements
- R1: After reset the time code (seconds and nanoseconds) and the free-running count are zero, the active increment is 0x8000_0000, and each value advances by 8 ns per clock.
- R2: The active increment has 28 fractional bits. On each clock the fractional remainder is carried forward, so 0x8800_0000 advances the time by 17 ns over any two consecutive clocks.
- R3: When the nanoseconds would reach 1,000,000,000 or more, they wrap to the excess and the seconds increase by one.
- R4: Writes to the shadow registers have no effect on the running time or the rate until a frame-sync event. The shadow increment is written low half at address 4 and high half at address 5. The shadow time code is at addresses 0/1 (nanoseconds low/high) and 2/3 (seconds low/high).
- R5: A frame-sync event happens only on a write to CTRL (address 10) that sets bit 2 while the stored bit 2 is 0. Writing bit 2 again while it is already 1 commits nothing.
- R6: The time code is committed only if LOAD_SEL (address 9) bit 0 is set and CTRL bit 0 (init) is set in the frame-sync write. After the commit, LOAD_SEL bit 0 reads back as 0.
- R7: The free-running count takes the 44-bit value written over addresses 6 (bits 15:0), 7 (bits 31:16) and 8 (bits 43:32, 12 bits), shifted left by 4. This happens on a frame-sync with LOAD_SEL bit 1 and init set. After the commit, LOAD_SEL bit 1 reads back as 0.
- R8: The shadow increment becomes active on any frame-sync while LOAD_SEL bit 2 is set, with or without init. That select bit stays set. The active increment reads back at addresses 4 and 5.
- R9: A frame-sync write with CTRL bit 1 set copies the seconds and nanoseconds held just before that edge into the heartbeat registers: nanoseconds at 16/17 (low/high) and seconds at 18/19. It also sets STATUS (address 12) bit 0.
- R10: Writing HB_CTRL (address 11) with bit 0 set freezes the heartbeat registers, so later captures leave them unchanged (STATUS bit 1 shows the freeze). Writing bit 1 clears STATUS bit 0. A write of zero after that releases the freeze.
- R11: A read strobe returns the addressed register on rdata_o one clock later. In any clock without a read, rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 125 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid one clock after rd_i |
| time_sec_o | output | 32 | Seconds of the time code |
| time_ns_o | output | 32 | Nanoseconds of the time code |
| nco_ns_o | output | 48 | Free-running nanosecond count |

## Verification
The time outputs move on the clock edge that follows a tick or a committing write. So the time code, the free-running count and the active rate all show a frame-sync commit at the first sample after the edge that took the CTRL write. Heartbeat contents, status and LOAD_SEL show it in the same way, but they can only be seen through a read, whose data arrives one clock after the strobe. The bench samples on the falling edge, half a cycle after each rising edge. A behavioural model updated on the same rising edge predicts all four outputs, and the bench compares them on every clock. Directed checks then confirm exact values at the sample right after each commit, and confirm rates as differences over one or two clocks.

// File: rtl/ptp_trim_pkg.sv
package ptp_trim_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_TC_NS_LO  = 5'd0,
    A_TC_NS_HI  = 5'd1,
    A_TC_SEC_LO = 5'd2,
    A_TC_SEC_HI = 5'd3,
    A_FREQ_LO   = 5'd4,
    A_FREQ_HI   = 5'd5,
    A_NCO_0     = 5'd6,
    A_NCO_1     = 5'd7,
    A_NCO_2     = 5'd8,
    A_LOAD_SEL  = 5'd9,
    A_CTRL      = 5'd10,
    A_HB_CTRL   = 5'd11,
    A_STATUS    = 5'd12,
    A_HB_NS_LO  = 5'd16,
    A_HB_NS_HI  = 5'd17,
    A_HB_SEC_LO = 5'd18,
    A_HB_SEC_HI = 5'd19
  } reg_addr_e;

  // CTRL bits
  localparam int CTRL_INIT  = 0;
  localparam int CTRL_CAP   = 1;
  localparam int CTRL_FSYNC = 2;
  // LOAD_SEL bits
  localparam int SEL_TIME = 0;
  localparam int SEL_NCO  = 1;
  localparam int SEL_FREQ = 2;
  // HB_CTRL bits
  localparam int HB_START = 0;
  localparam int HB_END   = 1;

  localparam logic [31:0] FREQ_NOMINAL = 32'h8000_0000;
  localparam logic [31:0] NS_PER_SEC   = 32'd1_000_000_000;
endpackage

// File: rtl/ptp_trim_regs.sv
module ptp_trim_regs
  import ptp_trim_pkg::*;
#(
  parameter int NS_W   = 32,
  parameter int SEC_W  = 32,
  parameter int FREQ_W = 32,
  parameter int NCO_W  = 44
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [NS_W-1:0]     tc_ns_o,
  output logic [SEC_W-1:0]    tc_sec_o,
  output logic [FREQ_W-1:0]   freq_stage_o,
  output logic [NCO_W-1:0]    nco_stage_o,
  output logic                tc_load_o,
  output logic                nco_load_o,
  output logic                freq_load_o,
  output logic                capture_o,
  output logic                hb_start_o,
  output logic                hb_end_o,
  output logic                hb_zero_o,
  output logic [2:0]          ctrl_o,
  output logic [2:0]          sel_o
);
  localparam int NCO_TOP_W = NCO_W - 2*DATA_W;

  logic [2:0] ctrl_q, sel_q;
  logic       ctrl_wr, hb_wr, fsync;

  assign ctrl_wr = wr_i && (addr_i == A_CTRL);
  assign hb_wr   = wr_i && (addr_i == A_HB_CTRL);
  assign fsync   = ctrl_wr && wdata_i[CTRL_FSYNC] && !ctrl_q[CTRL_FSYNC];

  assign tc_load_o   = fsync && wdata_i[CTRL_INIT] && sel_q[SEL_TIME];
  assign nco_load_o  = fsync && wdata_i[CTRL_INIT] && sel_q[SEL_NCO];
  assign freq_load_o = fsync && sel_q[SEL_FREQ];
  assign capture_o   = fsync && wdata_i[CTRL_CAP];
  assign hb_start_o  = hb_wr && wdata_i[HB_START];
  assign hb_end_o    = hb_wr && wdata_i[HB_END];
  assign hb_zero_o   = hb_wr && (wdata_i[1:0] == 2'b00);
  assign ctrl_o      = ctrl_q;
  assign sel_o       = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata_i[2:0];
      if (wr_i && addr_i == A_LOAD_SEL) begin
        sel_q <= wdata_i[2:0];
      end else begin
        if (tc_load_o)  sel_q[SEL_TIME] <= 1'b0;
        if (nco_load_o) sel_q[SEL_NCO]  <= 1'b0;
      end
    end
  end

  // shadow staging
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_ns_o      <= '0;
      tc_sec_o     <= '0;
      freq_stage_o <= '0;
      nco_stage_o  <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_TC_NS_LO:  tc_ns_o[DATA_W-1:0]           <= wdata_i;
        A_TC_NS_HI:  tc_ns_o[NS_W-1:DATA_W]        <= wdata_i[NS_W-DATA_W-1:0];
        A_TC_SEC_LO: tc_sec_o[DATA_W-1:0]          <= wdata_i;
        A_TC_SEC_HI: tc_sec_o[SEC_W-1:DATA_W]      <= wdata_i[SEC_W-DATA_W-1:0];
        A_FREQ_LO:   freq_stage_o[DATA_W-1:0]      <= wdata_i;
        A_FREQ_HI:   freq_stage_o[FREQ_W-1:DATA_W] <= wdata_i[FREQ_W-DATA_W-1:0];
        A_NCO_0:     nco_stage_o[DATA_W-1:0]       <= wdata_i;
        A_NCO_1:     nco_stage_o[2*DATA_W-1:DATA_W] <= wdata_i;
        A_NCO_2:     nco_stage_o[NCO_W-1:2*DATA_W] <= wdata_i[NCO_TOP_W-1:0];
        default: ;
      endcase
    end
  end

  a_r6_sel_autoclear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_load_o |=> !sel_q[SEL_TIME]);
  a_r7_nco_sel_autoclear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nco_load_o |=> !sel_q[SEL_NCO]);
  a_r5_edge_leaves_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_load_o || freq_load_o || capture_o) |=> ctrl_q[CTRL_FSYNC]);
endmodule

// File: rtl/ptp_trim_nco.sv
module ptp_trim_nco
  import ptp_trim_pkg::*;
#(
  parameter int NS_W   = 32,
  parameter int SEC_W  = 32,
  parameter int FREQ_W = 32,
  parameter int FRAC_W = 28,
  parameter int NCO_W  = 44
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [FREQ_W-1:0]    freq_stage_i,
  input  logic                 freq_load_i,
  input  logic [NS_W-1:0]      tc_ns_i,
  input  logic [SEC_W-1:0]     tc_sec_i,
  input  logic                 tc_load_i,
  input  logic [NCO_W-1:0]     nco_stage_i,
  input  logic                 nco_load_i,
  output logic [NS_W-1:0]      ns_o,
  output logic [SEC_W-1:0]     sec_o,
  output logic [NCO_W+3:0]     nco_o,
  output logic [FREQ_W-1:0]    freq_o
);
  localparam int STEP_W = FREQ_W - FRAC_W + 1;
  localparam int CNT_W  = NCO_W + 4;

  logic [FRAC_W-1:0] frac_q;
  logic [FREQ_W-1:0] freq_q;
  logic [NS_W-1:0]   ns_q, ns_sum;
  logic [SEC_W-1:0]  sec_q;
  logic [CNT_W-1:0]  nco_q;
  logic [FREQ_W:0]   acc_sum;
  logic [STEP_W-1:0] step;
  logic              wrap;

  assign acc_sum = {{(FREQ_W-FRAC_W+1){1'b0}}, frac_q} + {1'b0, freq_q};
  assign step    = acc_sum[FREQ_W:FRAC_W];
  assign ns_sum  = ns_q + NS_W'(step);
  assign wrap    = ns_sum >= NS_W'(NS_PER_SEC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q <= '0;
      freq_q <= FREQ_NOMINAL;
      ns_q   <= '0;
      sec_q  <= '0;
      nco_q  <= '0;
    end else begin
      frac_q <= acc_sum[FRAC_W-1:0];
      if (freq_load_i) freq_q <= freq_stage_i;
      if (tc_load_i) begin
        ns_q  <= tc_ns_i;
        sec_q <= tc_sec_i;
      end else if (wrap) begin
        ns_q  <= ns_sum - NS_W'(NS_PER_SEC);
        sec_q <= sec_q + 1'b1;
      end else begin
        ns_q  <= ns_sum;
      end
      if (nco_load_i) nco_q <= {nco_stage_i, 4'b0000};
      else            nco_q <= nco_q + CNT_W'(step);
    end
  end

  assign ns_o   = ns_q;
  assign sec_o  = sec_q;
  assign nco_o  = nco_q;
  assign freq_o = freq_q;

  a_r3_ns_below_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tc_load_i && ns_q < NS_W'(NS_PER_SEC)) |=> ns_q < NS_W'(NS_PER_SEC));
  a_r6_time_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_load_i |=> (ns_q == $past(tc_ns_i) && sec_q == $past(tc_sec_i)));
  a_r8_freq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freq_load_i |=> $stable(freq_q));
endmodule

// File: rtl/ptp_trim_heartbeat.sv
module ptp_trim_heartbeat #(
  parameter int NS_W  = 32,
  parameter int SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             hb_start_i,
  input  logic             hb_end_i,
  input  logic             hb_zero_i,
  output logic [NS_W-1:0]  hb_ns_o,
  output logic [SEC_W-1:0] hb_sec_o,
  output logic             status_o,
  output logic             frozen_o
);
  logic [NS_W-1:0]  hb_ns_q;
  logic [SEC_W-1:0] hb_sec_q;
  logic             status_q, frozen_q, end_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_ns_q    <= '0;
      hb_sec_q   <= '0;
      status_q   <= 1'b0;
      frozen_q   <= 1'b0;
      end_seen_q <= 1'b0;
    end else begin
      if (capture_i && !frozen_q) begin
        hb_ns_q  <= ns_i;
        hb_sec_q <= sec_i;
      end
      if (capture_i)     status_q <= 1'b1;
      else if (hb_end_i) status_q <= 1'b0;
      if (hb_start_i) frozen_q <= 1'b1;
      if (hb_end_i)   end_seen_q <= 1'b1;
      if (hb_zero_i && end_seen_q) begin
        frozen_q   <= 1'b0;
        end_seen_q <= 1'b0;
      end
    end
  end

  assign hb_ns_o  = hb_ns_q;
  assign hb_sec_o = hb_sec_q;
  assign status_o = status_q;
  assign frozen_o = frozen_q;

  a_r10_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_q |=> ($stable(hb_ns_q) && $stable(hb_sec_q)));
  a_r9_status_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> status_q);
  a_r10_status_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hb_end_i && !capture_i) |=> !status_q);
endmodule

// File: rtl/ptp_trim_clock.sv
module ptp_trim_clock
  import ptp_trim_pkg::*;
#(
  parameter int NS_W   = 32,
  parameter int SEC_W  = 32,
  parameter int FREQ_W = 32,
  parameter int FRAC_W = 28,
  parameter int NCO_W  = 44
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [SEC_W-1:0]    time_sec_o,
  output logic [NS_W-1:0]     time_ns_o,
  output logic [NCO_W+3:0]    nco_ns_o
);
  logic [NS_W-1:0]   tc_ns, hb_ns;
  logic [SEC_W-1:0]  tc_sec, hb_sec;
  logic [FREQ_W-1:0] freq_stage, freq_act;
  logic [NCO_W-1:0]  nco_stage;
  logic tc_load, nco_load, freq_load, capture;
  logic hb_start, hb_end, hb_zero, status, frozen;
  logic [2:0] ctrl, sel;
  logic [DATA_W-1:0] rmux, rdata_q;

  ptp_trim_regs #(.NS_W(NS_W), .SEC_W(SEC_W), .FREQ_W(FREQ_W), .NCO_W(NCO_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .tc_ns_o(tc_ns), .tc_sec_o(tc_sec), .freq_stage_o(freq_stage), .nco_stage_o(nco_stage),
    .tc_load_o(tc_load), .nco_load_o(nco_load), .freq_load_o(freq_load), .capture_o(capture),
    .hb_start_o(hb_start), .hb_end_o(hb_end), .hb_zero_o(hb_zero),
    .ctrl_o(ctrl), .sel_o(sel)
  );

  ptp_trim_nco #(.NS_W(NS_W), .SEC_W(SEC_W), .FREQ_W(FREQ_W), .FRAC_W(FRAC_W), .NCO_W(NCO_W)) u_nco (
    .clk_i, .rst_ni,
    .freq_stage_i(freq_stage), .freq_load_i(freq_load),
    .tc_ns_i(tc_ns), .tc_sec_i(tc_sec), .tc_load_i(tc_load),
    .nco_stage_i(nco_stage), .nco_load_i(nco_load),
    .ns_o(time_ns_o), .sec_o(time_sec_o), .nco_o(nco_ns_o), .freq_o(freq_act)
  );

  ptp_trim_heartbeat #(.NS_W(NS_W), .SEC_W(SEC_W)) u_hb (
    .clk_i, .rst_ni, .capture_i(capture), .ns_i(time_ns_o), .sec_i(time_sec_o),
    .hb_start_i(hb_start), .hb_end_i(hb_end), .hb_zero_i(hb_zero),
    .hb_ns_o(hb_ns), .hb_sec_o(hb_sec), .status_o(status), .frozen_o(frozen)
  );

  always_comb begin
    rmux = '0;
    case (addr_i)
      A_FREQ_LO:   rmux = freq_act[DATA_W-1:0];
      A_FREQ_HI:   rmux = DATA_W'(freq_act[FREQ_W-1:DATA_W]);
      A_LOAD_SEL:  rmux = DATA_W'(sel);
      A_CTRL:      rmux = DATA_W'(ctrl);
      A_STATUS:    rmux = DATA_W'({frozen, status});
      A_HB_NS_LO:  rmux = hb_ns[DATA_W-1:0];
      A_HB_NS_HI:  rmux = DATA_W'(hb_ns[NS_W-1:DATA_W]);
      A_HB_SEC_LO: rmux = hb_sec[DATA_W-1:0];
      A_HB_SEC_HI: rmux = DATA_W'(hb_sec[SEC_W-1:DATA_W]);
      default:     rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_i ? rmux : '0;
  end
  assign rdata_o = rdata_q;

  a_r11_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0);
endmodule

// File: tb/tb_ptp_trim_clock.sv
module tb_ptp_trim_clock;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [31:0] time_sec_o, time_ns_o;
  logic [47:0] nco_ns_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  ptp_trim_clock dut (
    .clk_i(clk), .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .time_sec_o, .time_ns_o, .nco_ns_o
  );

  // behavioural reference
  longint unsigned m_ns, m_sec, m_nco, m_frac, m_freq, m_sfreq;
  longint unsigned m_tcns, m_tcsec, m_ncost, m_hbns, m_hbsec;
  longint unsigned m_rd;
  bit [2:0] m_ctrl, m_sel;
  bit m_stat, m_frz, m_endp;

  function automatic longint unsigned mread(input int a);
    case (a)
      4:  return m_freq & 16'hffff;
      5:  return (m_freq >> 16) & 16'hffff;
      9:  return m_sel;
      10: return m_ctrl;
      12: return {m_frz, m_stat};
      16: return m_hbns & 16'hffff;
      17: return (m_hbns >> 16) & 16'hffff;
      18: return m_hbsec & 16'hffff;
      19: return (m_hbsec >> 16) & 16'hffff;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ns = 0; m_sec = 0; m_nco = 0; m_frac = 0; m_freq = 64'h8000_0000; m_sfreq = 0;
      m_tcns = 0; m_tcsec = 0; m_ncost = 0; m_hbns = 0; m_hbsec = 0; m_rd = 0;
      m_ctrl = 0; m_sel = 0; m_stat = 0; m_frz = 0; m_endp = 0;
    end else begin
      longint unsigned step, old_ns, old_sec;
      bit fs;
      int a;
      a = addr_i;
      m_rd = rd_i ? mread(a) : 0;
      step = (m_frac + m_freq) >> 28;
      m_frac = (m_frac + m_freq) % (64'd1 << 28);
      fs = wr_i && a == 10 && wdata_i[2] && !m_ctrl[2];
      old_ns = m_ns; old_sec = m_sec;
      m_ns = m_ns + step;
      if (m_ns >= 1000000000) begin m_ns -= 1000000000; m_sec = (m_sec + 1) % (64'd1 << 32); end
      m_nco = (m_nco + step) % (64'd1 << 48);
      if (fs && wdata_i[0] && m_sel[0]) begin m_ns = m_tcns; m_sec = m_tcsec; end
      if (fs && wdata_i[0] && m_sel[1]) m_nco = m_ncost * 16;
      if (fs && m_sel[2]) m_freq = m_sfreq;
      if (fs && wdata_i[1]) begin
        if (!m_frz) begin m_hbns = old_ns; m_hbsec = old_sec; end
        m_stat = 1;
      end
      if (wr_i && a == 11) begin
        if (wdata_i[0]) m_frz = 1;
        if (wdata_i[1]) begin m_endp = 1; m_stat = 0; end
        if (wdata_i[1:0] == 0 && m_endp) begin m_frz = 0; m_endp = 0; end
      end
      if (wr_i && a == 9) m_sel = wdata_i[2:0];
      else if (fs && wdata_i[0]) m_sel[1:0] = 2'b00;
      if (wr_i) begin
        case (a)
          0: m_tcns  = (m_tcns  & 64'hffff_0000) | wdata_i;
          1: m_tcns  = (m_tcns  & 64'h0000_ffff) | (longint'(wdata_i) << 16);
          2: m_tcsec = (m_tcsec & 64'hffff_0000) | wdata_i;
          3: m_tcsec = (m_tcsec & 64'h0000_ffff) | (longint'(wdata_i) << 16);
          4: m_sfreq = (m_sfreq & 64'hffff_0000) | wdata_i;
          5: m_sfreq = (m_sfreq & 64'h0000_ffff) | (longint'(wdata_i) << 16);
          6: m_ncost = (m_ncost & 64'hfff_ffff_0000) | wdata_i;
          7: m_ncost = (m_ncost & 64'hfff_0000_ffff) | (longint'(wdata_i) << 16);
          8: m_ncost = (m_ncost & 64'h000_ffff_ffff) | (longint'(wdata_i & 16'h0fff) << 32);
          10: m_ctrl = wdata_i[2:0];
          default: ;
        endcase
      end
    end
  end

  // cycle compare, half a period after each rising edge
  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (time_ns_o != m_ns[31:0] || time_sec_o != m_sec[31:0] ||
          nco_ns_o != m_nco[47:0] || rdata_o != m_rd[15:0]) begin
        n_fail++;
        $display("FAIL %s cycle compare: act ns=%0d sec=%0d nco=%0h rd=%0h exp ns=%0d sec=%0d nco=%0h rd=%0h",
                 cur_req, time_ns_o, time_sec_o, nco_ns_o, rdata_o, m_ns, m_sec, m_nco, m_rd);
      end
    end
  end

  task automatic chk(input string req, input string what, input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic wr(input int a, input int d);
    wr_i = 1'b1; addr_i = 5'(a); wdata_i = 16'(d);
    @(posedge clk); @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_i = 1'b1; addr_i = 5'(a);
    @(posedge clk); @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int d, d2;
    longint unsigned a0, a1, a2, t_ns, t_sec;
    // R1 reset state
    idle(2);
    chk("R1", "ns in reset", time_ns_o, 0);
    chk("R1", "nco in reset", nco_ns_o, 0);
    rst_ni = 1'b1;
    idle(3);
    a0 = time_ns_o; idle(1); a1 = time_ns_o;
    chk("R1", "nominal step", a1 - a0, 8);
    rd(5, d);
    chk("R1", "active freq hi", d, 16'h8000);

    // R4 staging, R8 freq commit, R2 fractional step
    cur_req = "R4";
    wr(4, 16'h0000); wr(5, 16'h8800); wr(9, 4);
    a0 = time_ns_o; idle(1); a1 = time_ns_o;
    chk("R4", "staged freq inert", a1 - a0, 8);
    cur_req = "R8";
    wr(10, 4);
    a0 = time_ns_o; idle(2); a2 = time_ns_o;
    cur_req = "R2";
    chk("R2", "8.5 ns two-clock step", a2 - a0, 17);
    rd(5, d);
    chk("R8", "active freq hi", d, 16'h8800);
    rd(9, d);
    chk("R8", "freq select kept", d, 4);

    // R5 no edge -> no commit
    cur_req = "R5";
    wr(5, 16'h9000);
    wr(10, 4);
    a0 = time_ns_o; idle(2); a2 = time_ns_o;
    chk("R5", "repeat high no commit", a2 - a0, 17);
    wr(10, 0); wr(10, 4);
    a0 = time_ns_o; idle(1); a1 = time_ns_o;
    chk("R5", "rising edge commits 9 ns", a1 - a0, 9);

    // R6 time commit needs init
    cur_req = "R6";
    wr(9, 1);
    wr(0, 16'hC99C); wr(1, 16'h3B9A); wr(2, 5); wr(3, 0);
    wr(10, 0); wr(10, 4);
    chk("R6", "no init no time load", time_sec_o, 0);
    wr(10, 0); wr(10, 5);
    chk("R6", "loaded ns", time_ns_o, 999_999_900);
    chk("R6", "loaded sec", time_sec_o, 5);
    rd(9, d);
    chk("R6", "time select cleared", d, 0);
    cur_req = "R3";
    idle(20);
    chk("R3", "seconds carry", time_sec_o, 6);
    chk("R3", "ns wrapped below 1e9", time_ns_o < 1_000_000_000, 1);

    // R7 free-running count load
    cur_req = "R7";
    wr(6, 16'h89AB); wr(7, 16'h4567); wr(8, 16'hF123);
    wr(9, 2); wr(10, 0); wr(10, 5);
    chk("R7", "nco loaded", nco_ns_o, 48'h1234_5678_9AB0);
    rd(9, d);
    chk("R7", "nco select cleared", d, 0);

    // R9 capture, R11 read latency
    cur_req = "R9";
    wr(10, 0);
    t_ns = time_ns_o; t_sec = time_sec_o;
    wr(10, 6);
    rd(12, d);
    chk("R9", "status set", d & 1, 1);
    rd(16, d); rd(17, d2);
    chk("R9", "hb ns", (d2 << 16) | d, t_ns);
    rd(18, d); rd(19, d2);
    chk("R9", "hb sec", (d2 << 16) | d, t_sec);
    cur_req = "R11";
    rd_i = 1'b1; addr_i = 5'd5;
    @(posedge clk); @(negedge clk);
    rd_i = 1'b0;
    chk("R11", "read data next clock", rdata_o, 16'h9000);
    idle(1);
    chk("R11", "idle read zero", rdata_o, 0);

    // R10 freeze handshake
    cur_req = "R10";
    wr(11, 1);
    wr(10, 0); wr(10, 6);
    rd(16, d); rd(17, d2);
    chk("R10", "frozen hb ns", (d2 << 16) | d, t_ns);
    rd(12, d);
    chk("R10", "frozen flag and status", d, 3);
    wr(11, 2);
    rd(12, d);
    chk("R10", "status cleared, still frozen", d, 2);
    wr(11, 0);
    rd(12, d);
    chk("R10", "released", d, 0);
    wr(10, 0);
    t_ns = time_ns_o;
    wr(10, 6);
    rd(16, d); rd(17, d2);
    chk("R10", "hb updates after release", (d2 << 16) | d, t_ns);

    idle(4);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: act running exp finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule